// File: doc/BRIEF.md
# Byte-Lane Write and Sleep Controller

This block is the data-side controller of a flow-through synchronous SRAM. Each rising clock edge samples a chip select, an address, a global write, a byte-write enable and active-low per-lane selects. From these it builds one registered write strobe for each byte lane. The strobes feed a small behavioural array with one slice per lane. The array commits them on the following edge. Read data is returned combinationally from the registered address within the same cycle.

The data-output enable follows the registered cycle type. It is also gated without a clock by an active-low output-enable input and by the sleep state. A sleep request input passes through a two-flop synchronizer and a two-cycle entry count before the controller goes to sleep. While asleep the controller ignores every cycle input and keeps the memory contents. When it wakes, a recovery window of a set number of cycles follows. During that window reads and deselects run normally, and writes are discarded and flagged.

Top module: `sram_lane_ctrl`

## Requirements
- R1: When `gw_n` is low in a selected cycle, `wstrb_o` becomes all ones after the sampling edge, whatever `bw_n` and `bsel_n` are.
- R2: When `gw_n` is high and `bw_n` is low, bit i of `wstrb_o` is set exactly when `bsel_n[i]` is low. Lane i carries data bits [8i+7:8i]. An all-high `bsel_n` is a write cycle that writes no lane.
- R3: When both `gw_n` and `bw_n` are high, the cycle is a read with no strobes. `rdata_o` shows the word at the registered address in the cycle right after the sampling edge, and it includes a write committed on that same edge.
- R4: `dq_oe` can be high only in a read cycle, where it covers all lanes whatever `bsel_n` is. In every write cycle it stays low.
- R5: `oe_n` high forces `dq_oe` low with no clock edge. `oe_n` low raises `dq_oe` only in a read cycle.
- R6: A cycle sampled with `sel_i` low writes nothing and leaves `dq_oe` low.
- R7: If `zz_i` is high at edge E0 and stays high, `asleep_o` rises after edge E3 and not before.
- R8: While asleep, or on the edge that enters sleep, sampled cycle inputs are ignored. No strobes are raised, `dq_oe` stays low, and the memory contents are kept.
- R9: If `zz_i` is low at edge F0 and stays low, `asleep_o` falls after edge F2. The next REC_CYC edges drop writes and accept reads. A write at the edge after that is performed.
- R10: A write dropped during recovery sets `wr_err_o`, which stays high until reset.
- R11: While reset is held and right after it: no strobes, `dq_oe` low, not asleep, `wr_err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| zz_i | input | 1 | Sleep request, asynchronous, active high |
| sel_i | input | 1 | Chip selected for this cycle, active high |
| addr_i | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Flow-through read data |
| dq_oe | output | 1 | Data drivers on; low means high impedance |
| wstrb_o | output | LANES | Per-lane write strobes of the current cycle |
| asleep_o | output | 1 | Sleep state |
| wr_err_o | output | 1 | Sticky flag for a write dropped during recovery |

## Verification
The bench uses the default parameters: four 8-bit lanes, a 16-word array, a two-cycle entry count and REC_CYC of 4. With a recovery window of four edges, both the first dropped write and the first accepted write after the window can be reached within a few cycles. The small array lets the bench keep a complete model of its contents. That model shows that lane merging and the data held through sleep are correct.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_RD   = 2'd1,
        CYC_WR   = 2'd2
    } cyc_e;
endpackage

// File: rtl/lane_wr_decode.sv
module lane_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] bsel_n,
    output logic             is_wr,
    output logic [LANES-1:0] lanes
);
    always_comb begin
        if (!gw_n) begin
            is_wr = 1'b1;
            lanes = '1;
        end else if (!bw_n) begin
            is_wr = 1'b1;
            lanes = ~bsel_n;
        end else begin
            is_wr = 1'b0;
            lanes = '0;
        end
    end
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq #(
    parameter int SLEEP_DLY = 2,
    parameter int REC_CYC   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zz_i,
    output logic asleep_o,
    output logic hold_o,
    output logic recov_o
);
    localparam int EW = (SLEEP_DLY > 1) ? $clog2(SLEEP_DLY) : 1;
    localparam int RW = $clog2(REC_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [EW-1:0] ent;
        logic          asleep;
        logic [RW-1:0] rec;
    } slp_s;

    slp_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = zz_i;
        st_d.s2 = st_q.s1;
        if (st_q.asleep) begin
            st_d.ent = '0;
            st_d.rec = '0;
            if (!st_q.s2) begin
                st_d.asleep = 1'b0;
                st_d.rec    = RW'(REC_CYC);
            end
        end else begin
            if (st_q.rec != '0) st_d.rec = st_q.rec - 1'b1;
            if (st_q.s2) begin
                if (st_q.ent == EW'(SLEEP_DLY - 1)) begin
                    st_d.asleep = 1'b1;
                    st_d.ent    = '0;
                end else begin
                    st_d.ent = st_q.ent + 1'b1;
                end
            end else begin
                st_d.ent = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign asleep_o = st_q.asleep;
    assign hold_o   = st_q.asleep | st_d.asleep;
    assign recov_o  = (st_q.rec != '0);
endmodule

// File: rtl/lane_mem.sv
module lane_mem #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          we,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g]) arr[addr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = arr[addr];
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int SLEEP_DLY = 2,
    parameter int REC_CYC   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     zz_i,
    input  logic                     sel_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     gw_n,
    input  logic                     bw_n,
    input  logic [LANES-1:0]         bsel_n,
    input  logic                     oe_n,
    input  logic [LANES*LANE_W-1:0]  wdata_i,
    output logic [LANES*LANE_W-1:0]  rdata_o,
    output logic                     dq_oe,
    output logic [LANES-1:0]         wstrb_o,
    output logic                     asleep_o,
    output logic                     wr_err_o
);
    import sram_lane_pkg::*;

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        cyc_e              kind;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wdata;
        logic [LANES-1:0]  strb;
        logic              err;
    } cyc_s;

    cyc_s cy_d, cy_q;

    logic             is_wr;
    logic [LANES-1:0] dec_lanes;
    logic             hold;
    logic             wr_block;
    logic             accept;

    lane_wr_decode #(.LANES(LANES)) u_dec (
        .gw_n   (gw_n),
        .bw_n   (bw_n),
        .bsel_n (bsel_n),
        .is_wr  (is_wr),
        .lanes  (dec_lanes)
    );

    sleep_seq #(.SLEEP_DLY(SLEEP_DLY), .REC_CYC(REC_CYC)) u_slp (
        .clk      (clk),
        .rst_n    (rst_n),
        .zz_i     (zz_i),
        .asleep_o (asleep_o),
        .hold_o   (hold),
        .recov_o  (wr_block)
    );

    assign accept = ~hold;

    always_comb begin
        cy_d      = cy_q;
        cy_d.kind = CYC_IDLE;
        cy_d.strb = '0;
        if (accept && sel_i) begin
            cy_d.addr = addr_i;
            if (is_wr) begin
                if (wr_block) begin
                    cy_d.err = 1'b1;
                end else begin
                    cy_d.kind  = CYC_WR;
                    cy_d.wdata = wdata_i;
                    cy_d.strb  = dec_lanes;
                end
            end else begin
                cy_d.kind = CYC_RD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cy_q.kind  <= CYC_IDLE;
            cy_q.addr  <= '0;
            cy_q.wdata <= '0;
            cy_q.strb  <= '0;
            cy_q.err   <= 1'b0;
        end else begin
            cy_q <= cy_d;
        end
    end

    lane_mem #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .addr  (cy_q.addr),
        .we    (cy_q.strb),
        .wdata (cy_q.wdata),
        .rdata (rdata_o)
    );

    assign wstrb_o  = cy_q.strb;
    assign wr_err_o = cy_q.err;
    assign dq_oe    = (cy_q.kind == CYC_RD) && !oe_n && !asleep_o;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_i,
    input logic             gw_n,
    input logic             bw_n,
    input logic [LANES-1:0] bsel_n,
    input logic             oe_n,
    input logic [LANES-1:0] wstrb_o,
    input logic             dq_oe,
    input logic             asleep_o,
    input logic             wr_err_o,
    input logic             accept,
    input logic             wr_block
);
    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_block && sel_i && !gw_n) |=> (wstrb_o == {LANES{1'b1}})); // R1
    AST_BW_LANE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_block && sel_i && gw_n && !bw_n) |=> (wstrb_o == ~$past(bsel_n))); // R2
    AST_RD_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && gw_n && bw_n) |=> (wstrb_o == '0)); // R3
    AST_NO_DRIVE_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (wstrb_o == '0)); // R4
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R5
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> ((wstrb_o == '0) && !dq_oe)); // R6
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_o |-> ((wstrb_o == '0) && !dq_oe)); // R8
    AST_RECOV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |=> (wstrb_o == '0)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |=> wr_err_o); // R10
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .gw_n     (gw_n),
    .bw_n     (bw_n),
    .bsel_n   (bsel_n),
    .oe_n     (oe_n),
    .wstrb_o  (wstrb_o),
    .dq_oe    (dq_oe),
    .asleep_o (asleep_o),
    .wr_err_o (wr_err_o),
    .accept   (accept),
    .wr_block (wr_block)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        zz_i = 1'b0;
    logic        sel_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        gw_n = 1'b1;
    logic        bw_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        oe_n = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        dq_oe;
    logic [3:0]  wstrb_o;
    logic        asleep_o;
    logic        wr_err_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mdl [16];

    always #5 clk = ~clk;

    sram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .zz_i(zz_i), .sel_i(sel_i), .addr_i(addr_i),
        .gw_n(gw_n), .bw_n(bw_n), .bsel_n(bsel_n), .oe_n(oe_n), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .dq_oe(dq_oe), .wstrb_o(wstrb_o), .asleep_o(asleep_o),
        .wr_err_o(wr_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in;
        sel_i = 1'b0; gw_n = 1'b1; bw_n = 1'b1; bsel_n = 4'hF;
    endtask

    function automatic logic [3:0] exp_lanes(input logic g, input logic b, input logic [3:0] bs);
        if (!g) return 4'hF;
        if (!b) return ~bs;
        return 4'h0;
    endfunction

    task automatic model_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] ln);
        for (int i = 0; i < 4; i++)
            if (ln[i]) mdl[a][i*8 +: 8] = d[i*8 +: 8];
    endtask

    task automatic wr_cyc(input string req, input logic [3:0] a, input logic [31:0] d,
                          input logic g, input logic b, input logic [3:0] bs);
        sel_i = 1'b1; addr_i = a; wdata_i = d; gw_n = g; bw_n = b; bsel_n = bs;
        step();
        chk(req, {28'd0, wstrb_o}, {28'd0, exp_lanes(g, b, bs)});
        chk("R4 write hi-z", {31'd0, dq_oe}, 32'd0);
        model_wr(a, d, exp_lanes(g, b, bs));
        idle_in();
    endtask

    task automatic rd_cyc(input string req, input logic [3:0] a, input logic [3:0] bs);
        sel_i = 1'b1; addr_i = a; gw_n = 1'b1; bw_n = 1'b1; bsel_n = bs;
        step();
        chk(req, rdata_o, mdl[a]);
        chk("R3 read no strobes", {28'd0, wstrb_o}, 32'd0);
        chk("R4 read drives", {31'd0, dq_oe}, 32'd1);
        idle_in();
    endtask

    task automatic t_reset;
        chk("R11 strobes in reset", {28'd0, wstrb_o}, 32'd0);
        chk("R11 oe in reset", {31'd0, dq_oe}, 32'd0);
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R11 not asleep", {31'd0, asleep_o}, 32'd0);
        chk("R11 err clear", {31'd0, wr_err_o}, 32'd0);
    endtask

    task automatic t_global;
        wr_cyc("R1 gw all lanes", 4'd3, 32'hA1B2C3D4, 1'b0, 1'b1, 4'hF);
        rd_cyc("R3 flow-through read", 4'd3, 4'hF);
        wr_cyc("R1 gw over bw", 4'd5, 32'h11223344, 1'b0, 1'b0, 4'hE);
        rd_cyc("R1 readback", 4'd5, 4'h0);
    endtask

    task automatic t_bytes;
        wr_cyc("R2 lanes 0,2", 4'd3, 32'h55667788, 1'b1, 1'b0, 4'b1010);
        rd_cyc("R2 merged word", 4'd3, 4'hF);
        wr_cyc("R2 lane 3 only", 4'd5, 32'hEE000000, 1'b1, 1'b0, 4'b0111);
        wr_cyc("R2 no lanes", 4'd5, 32'hDEADBEEF, 1'b1, 1'b0, 4'hF);
        rd_cyc("R2 no-lane write kept data", 4'd5, 4'hF);
    endtask

    task automatic t_oe;
        sel_i = 1'b1; addr_i = 4'd3; gw_n = 1'b1; bw_n = 1'b1;
        step();
        chk("R5 read with oe low", {31'd0, dq_oe}, 32'd1);
        oe_n = 1'b1; #1;
        chk("R5 oe high disables", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0; #1;
        chk("R5 oe low re-enables", {31'd0, dq_oe}, 32'd1);
        idle_in();
        wr_cyc("R5 write with oe low", 4'd7, 32'h0BADF00D, 1'b0, 1'b1, 4'hF);
        chk("R5 no drive in write", {31'd0, dq_oe}, 32'd0);
    endtask

    task automatic t_desel;
        sel_i = 1'b0; addr_i = 4'd7; gw_n = 1'b0; wdata_i = 32'hFFFFFFFF;
        step();
        chk("R6 deselect no strobes", {28'd0, wstrb_o}, 32'd0);
        chk("R6 deselect hi-z", {31'd0, dq_oe}, 32'd0);
        idle_in();
        rd_cyc("R6 data untouched", 4'd7, 4'hF);
    endtask

    task automatic t_sleep;
        zz_i = 1'b1;
        step();                                   // E0
        step();                                   // E1
        step();                                   // E2
        chk("R7 awake after E2", {31'd0, asleep_o}, 32'd0);
        step();                                   // E3
        chk("R7 asleep after E3", {31'd0, asleep_o}, 32'd1);
        sel_i = 1'b1; addr_i = 4'd3; gw_n = 1'b0; wdata_i = 32'h99999999;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8 no strobes asleep", {28'd0, wstrb_o}, 32'd0);
            chk("R8 hi-z asleep", {31'd0, dq_oe}, 32'd0);
        end
        gw_n = 1'b1;
        step();
        chk("R8 read ignored asleep", {31'd0, dq_oe}, 32'd0);
        idle_in();
        zz_i = 1'b0;
        step();                                   // F0
        step();                                   // F1
        chk("R9 still asleep after F1", {31'd0, asleep_o}, 32'd1);
        step();                                   // F2
        chk("R9 awake after F2", {31'd0, asleep_o}, 32'd0);
        chk("R10 err clear before", {31'd0, wr_err_o}, 32'd0);
        sel_i = 1'b1; addr_i = 4'd3; gw_n = 1'b0; wdata_i = 32'h77777777;
        step();                                   // F3 dropped
        chk("R9 write dropped", {28'd0, wstrb_o}, 32'd0);
        chk("R10 err set", {31'd0, wr_err_o}, 32'd1);
        idle_in();
        rd_cyc("R8 memory kept, R9 read accepted", 4'd3, 4'hF);   // F4
        step(); step();                           // F5, F6
        wr_cyc("R9 write after window", 4'd9, 32'hCAFEBABE, 1'b0, 1'b1, 4'hF); // F7
        chk("R10 err sticky", {31'd0, wr_err_o}, 32'd1);
        rd_cyc("R9 post-window data", 4'd9, 4'hF);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        t_reset();
        t_global();
        t_bytes();
        t_oe();
        t_desel();
        t_sleep();
        step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule